// File: doc/BRIEF.md
# Three-Operand Integer ALU with Fill-Selectable Shifts

This is a purely combinational integer unit for a 32-bit register machine. It takes two source operands and a 12-bit extended opcode and produces one result word and an illegal-operation flag in the same cycle. Around it, a register file supplies the operands and captures the result. A sequencer uses the flag to trap or halt.

The extended opcode has two fields. Its upper 8 bits pick a subgroup and its low 4 bits pick the operation inside that subgroup. Four subgroups are implemented:

- arithmetic and compare
- min/max
- the two-input logic functions, including the implication forms
- shifts and rotates

A shift can fill the vacated bits with zeros, with ones, or with copies of the sign bit. Every other opcode value is reported as illegal.

Top module: `fill_shift_alu`

## Requirements
- R1: Opcodes 0x000 and 0x001 give opA + opB, and 0x002 and 0x003 give opA - opB. All four wrap modulo 2^32, and the signed and unsigned forms give the same bits.
- R2: Opcode 0x004 compares signed and 0x005 compares unsigned. Result bit 0 is set when opA < opB, bit 1 when they are equal, and bit 2 when opA > opB. All other bits are zero.
- R3: Opcodes 0x010, 0x011, 0x012 and 0x013 return signed max, unsigned max, signed min and unsigned min of opA and opB.
- R4: Opcodes 0x020 to 0x025 return AND, OR, XOR, NAND, NOR and XNOR of opA and opB, bitwise.
- R5: The implication forms are bitwise:
  - 0x026 gives ~opA & opB.
  - 0x027 gives opA & ~opB.
  - 0x028 gives ~opA | opB.
  - 0x029 gives opA | ~opB.
- R6: The shifts by opB positions, for opB below 32, are:
  - 0x030 shifts left with zero fill.
  - 0x031 shifts right, filling with opA bit 31.
  - 0x032 shifts left with zero fill.
  - 0x033 shifts right with zero fill.
- R7: For opB below 32, opcode 0x034 shifts left and 0x035 shifts right, filling the vacated positions with ones.
- R8: Opcode 0x036 rotates opA left and 0x037 rotates it right, by opB modulo 32. Upper bits of opB have no effect.
- R9: A shift (0x030 to 0x035) whose opB is 32 or more returns a word made only of fill bits:
  - zero fill gives all zeros.
  - one fill gives all ones.
  - sign fill gives 32 copies of opA bit 31.
- R10: Every opcode outside the legal codes listed in R1 to R8 drives illegal to 1 and result to zero. Every legal opcode drives illegal to 0. The legal codes are 0x000-0x005, 0x010-0x013, 0x020-0x029 and 0x030-0x037.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First source operand; the shifted or rotated value for shifts |
| opB | input | 32 | Second source operand; the shift or rotate amount for shifts |
| xop | input | 12 | Extended opcode: [11:4] subgroup, [3:0] operation |
| result | output | 32 | Result word, zero when the opcode is illegal |
| illegal | output | 1 | High when xop is not a legal operation |

## Verification
The bench sweeps all 4096 opcode values against fourteen operand pairs, so each reserved code inside a legal subgroup is exercised. Many of those pairs sit on sign and width boundaries.

**Signed compares and min/max.** The operand pairs 0x80000000/0x7FFFFFFF and all-ones/one target these. A design that compared unsigned where it should compare signed would invert the less-than and greater-than bits for those pairs.

**Shift amounts.** Amounts 0, 31, 32 and 33 are applied, and 0xFFFFFFE1 is applied as well.
- A design that took only the low five bits of the amount would shift by 1 or 0 where the result must be pure fill.
- A rotate that failed to reduce the amount modulo 32 would collapse to zero.

**Fill and reserved codes.** A swapped fill kind shows as wrong upper or lower bits. A reserved code that leaked through decode would return a nonzero word with illegal low.

// File: rtl/fsalu_pkg.sv
package fsalu_pkg;

  localparam int SUBGRP_W = 8;
  localparam int CODE_W   = 4;
  localparam int XOP_W    = SUBGRP_W + CODE_W;

  localparam logic [SUBGRP_W-1:0] SG_ARITH = 8'h00;
  localparam logic [SUBGRP_W-1:0] SG_SORT  = 8'h01;
  localparam logic [SUBGRP_W-1:0] SG_LOGIC = 8'h02;
  localparam logic [SUBGRP_W-1:0] SG_SHIFT = 8'h03;

  typedef enum logic [2:0] {
    UNIT_NONE,
    UNIT_ADD,
    UNIT_CMP,
    UNIT_SORT,
    UNIT_LOGIC,
    UNIT_SHIFT
  } unitSel_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_ONE,
    FILL_SIGN
  } fill_e;

  // Strobes passed from decode to the datapath.
  typedef struct packed {
    unitSel_e   unit;
    logic       isSigned;
    logic       doSub;
    logic       pickMax;
    logic [3:0] truthTbl;   // output bit for each operand pair, indexed by {a,b}
    logic       shiftLeft;
    logic       rotate;
    fill_e      fill;
  } ctrlStrobes_t;

endpackage

// File: rtl/fsalu_ctrl.sv
module fsalu_ctrl
  import fsalu_pkg::*;
(
  input  logic [XOP_W-1:0] xop,
  output ctrlStrobes_t     strobes,
  output logic             illegal
);

  logic [SUBGRP_W-1:0] subGrp;
  logic [CODE_W-1:0]   code;

  assign subGrp = xop[XOP_W-1 -: SUBGRP_W];
  assign code   = xop[CODE_W-1:0];

  always_comb begin
    strobes           = '0;
    strobes.unit      = UNIT_NONE;
    strobes.fill      = FILL_ZERO;
    illegal           = 1'b0;
    case (subGrp)
      SG_ARITH: begin
        case (code)
          4'h0: begin strobes.unit = UNIT_ADD; strobes.isSigned = 1'b1; end       // R1
          4'h1: begin strobes.unit = UNIT_ADD; end
          4'h2: begin strobes.unit = UNIT_ADD; strobes.isSigned = 1'b1; strobes.doSub = 1'b1; end
          4'h3: begin strobes.unit = UNIT_ADD; strobes.doSub = 1'b1; end
          4'h4: begin strobes.unit = UNIT_CMP; strobes.isSigned = 1'b1; end       // R2
          4'h5: begin strobes.unit = UNIT_CMP; end
          default: illegal = 1'b1;                                                 // R10
        endcase
      end
      SG_SORT: begin                                                               // R3
        case (code)
          4'h0: begin strobes.unit = UNIT_SORT; strobes.isSigned = 1'b1; strobes.pickMax = 1'b1; end
          4'h1: begin strobes.unit = UNIT_SORT; strobes.pickMax = 1'b1; end
          4'h2: begin strobes.unit = UNIT_SORT; strobes.isSigned = 1'b1; end
          4'h3: begin strobes.unit = UNIT_SORT; end
          default: illegal = 1'b1;
        endcase
      end
      SG_LOGIC: begin
        strobes.unit = UNIT_LOGIC;
        case (code)
          4'h0: strobes.truthTbl = 4'b1000;   // R4 and
          4'h1: strobes.truthTbl = 4'b1110;   // or
          4'h2: strobes.truthTbl = 4'b0110;   // xor
          4'h3: strobes.truthTbl = 4'b0111;   // nand
          4'h4: strobes.truthTbl = 4'b0001;   // nor
          4'h5: strobes.truthTbl = 4'b1001;   // xnor
          4'h6: strobes.truthTbl = 4'b0010;   // R5 ~a & b
          4'h7: strobes.truthTbl = 4'b0100;   // a & ~b
          4'h8: strobes.truthTbl = 4'b1011;   // ~a | b
          4'h9: strobes.truthTbl = 4'b1101;   // a | ~b
          default: begin strobes.unit = UNIT_NONE; illegal = 1'b1; end
        endcase
      end
      SG_SHIFT: begin
        strobes.unit = UNIT_SHIFT;
        case (code)
          4'h0: begin strobes.shiftLeft = 1'b1; strobes.fill = FILL_ZERO; end     // R6
          4'h1: begin strobes.fill = FILL_SIGN; end
          4'h2: begin strobes.shiftLeft = 1'b1; strobes.fill = FILL_ZERO; end
          4'h3: begin strobes.fill = FILL_ZERO; end
          4'h4: begin strobes.shiftLeft = 1'b1; strobes.fill = FILL_ONE; end      // R7
          4'h5: begin strobes.fill = FILL_ONE; end
          4'h6: begin strobes.shiftLeft = 1'b1; strobes.rotate = 1'b1; end         // R8
          4'h7: begin strobes.rotate = 1'b1; end
          default: begin strobes.unit = UNIT_NONE; illegal = 1'b1; end
        endcase
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/fsalu_shifter.sv
module fsalu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] amount,
  input  logic              shiftLeft,
  input  logic              rotate,
  input  fsalu_pkg::fill_e  fill,
  output logic [DATA_W-1:0] shifted
);

  localparam int AMT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [AMT_W-1:0]    amtLow;
  logic                saturate;
  logic [DATA_W-1:0]   fillWord;
  logic [DATA_W-1:0]   leftOut;
  logic [DATA_W-1:0]   rightOut;
  logic [2*DATA_W-1:0] dblLeft;
  logic [2*DATA_W-1:0] dblRight;

  assign amtLow   = amount[AMT_W-1:0];
  // R9: any amount bit above the index range means the amount is at least DATA_W
  assign saturate = |amount[DATA_W-1:AMT_W];

  always_comb begin
    case (fill)
      fsalu_pkg::FILL_ONE:  fillWord = ALL_ONES;
      fsalu_pkg::FILL_SIGN: fillWord = {DATA_W{value[DATA_W-1]}};
      default:              fillWord = '0;
    endcase
  end

  assign leftOut  = (value << amtLow) | (fillWord & ~(ALL_ONES << amtLow));
  assign rightOut = (value >> amtLow) | (fillWord & ~(ALL_ONES >> amtLow));

  // R8: rotate through a doubled copy, using the low amount bits only
  assign dblLeft  = {value, value} << amtLow;
  assign dblRight = {value, value} >> amtLow;

  always_comb begin
    if (rotate)
      shifted = shiftLeft ? dblLeft[2*DATA_W-1:DATA_W] : dblRight[DATA_W-1:0];
    else if (saturate)
      shifted = fillWord;
    else
      shifted = shiftLeft ? leftOut : rightOut;
  end

endmodule

// File: rtl/fsalu_datapath.sv
module fsalu_datapath
  import fsalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobes_t      strobes,
  input  logic              illegal,
  output logic [DATA_W-1:0] result
);

  localparam int CMP_LT = 0;
  localparam int CMP_EQ = 1;
  localparam int CMP_GT = 2;

  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic              isLess;
  logic              isEqual;
  logic              isGreater;
  logic [DATA_W-1:0] cmpWord;
  logic [DATA_W-1:0] sortOut;
  logic [DATA_W-1:0] logicOut;
  logic [DATA_W-1:0] shiftOut;

  // R1: one adder serves add and subtract; signedness does not change the bits
  assign addend = strobes.doSub ? ~opB : opB;
  assign sum    = opA + addend + {{(DATA_W-1){1'b0}}, strobes.doSub};

  // R2, R3
  assign isEqual   = (opA == opB);
  assign isLess    = strobes.isSigned ? ($signed(opA) < $signed(opB)) : (opA < opB);
  assign isGreater = !isLess && !isEqual;

  always_comb begin
    cmpWord         = '0;
    cmpWord[CMP_LT] = isLess;
    cmpWord[CMP_EQ] = isEqual;
    cmpWord[CMP_GT] = isGreater;
  end

  assign sortOut = (strobes.pickMax == isGreater) ? opA : opB;

  // R4, R5: each bit looks up its operand pair in the truth table
  for (genvar i = 0; i < DATA_W; i++) begin : g_logicBit
    assign logicOut[i] = strobes.truthTbl[{opA[i], opB[i]}];
  end

  fsalu_shifter #(.DATA_W(DATA_W)) shifter_i (
    .value     (opA),
    .amount    (opB),
    .shiftLeft (strobes.shiftLeft),
    .rotate    (strobes.rotate),
    .fill      (strobes.fill),
    .shifted   (shiftOut)
  );

  always_comb begin
    if (illegal) begin
      result = '0;                      // R10
    end else begin
      case (strobes.unit)
        UNIT_ADD:   result = sum;
        UNIT_CMP:   result = cmpWord;
        UNIT_SORT:  result = sortOut;
        UNIT_LOGIC: result = logicOut;
        UNIT_SHIFT: result = shiftOut;
        default:    result = '0;
      endcase
    end
  end

endmodule

// File: rtl/fill_shift_alu.sv
module fill_shift_alu
  import fsalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [XOP_W-1:0]  xop,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  ctrlStrobes_t strobes;
  logic         illegalDec;

  fsalu_ctrl ctrl_i (
    .xop     (xop),
    .strobes (strobes),
    .illegal (illegalDec)
  );

  fsalu_datapath #(.DATA_W(DATA_W)) dp_i (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .illegal (illegalDec),
    .result  (result)
  );

  assign illegal = illegalDec;

endmodule

// File: rtl/fill_shift_alu_chk.sv
module fill_shift_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [11:0]       xop,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  always_comb begin
    if (illegal)
      AST_ILLEGAL_QUIET: assert (result == '0) else $error("illegal op gave nonzero result");  // R10
    if (xop == 12'h004 || xop == 12'h005)
      AST_CMP_ONEHOT: assert ($onehot(result[2:0]) && result[DATA_W-1:3] == '0) else $error("compare word malformed");  // R2
    if (xop == 12'h000)
      AST_ADD_WRAP: assert (result - opB == opA) else $error("add does not invert by subtract");  // R1
    if (xop == 12'h011)
      AST_UMAX_BOUND: assert (result >= opA && result >= opB) else $error("unsigned max below an operand");  // R3
    if (xop == 12'h033 && opB >= DATA_W)
      AST_SAT_ZERO: assert (result == '0) else $error("saturated zero-fill shift not zero");  // R9
    if (xop == 12'h034 && opB >= DATA_W)
      AST_SAT_ONES: assert (&result) else $error("saturated one-fill shift not all ones");  // R9
  end

endmodule

bind fill_shift_alu fill_shift_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/fill_shift_alu_tb_top.sv
module fill_shift_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PAT    = 14;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [11:0] xop = '0;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] patA [NUM_PAT];
  logic [31:0] patB [NUM_PAT];

  always #(CLK_PERIOD/2) clk = ~clk;

  fill_shift_alu dut_i (
    .opA     (opA),
    .opB     (opB),
    .xop     (xop),
    .result  (result),
    .illegal (illegal)
  );

  function automatic string reqTag(input logic [11:0] x, input logic [31:0] b);
    if (x <= 12'h003) return "R1";
    if (x == 12'h004 || x == 12'h005) return "R2";
    if (x >= 12'h010 && x <= 12'h013) return "R3";
    if (x >= 12'h020 && x <= 12'h025) return "R4";
    if (x >= 12'h026 && x <= 12'h029) return "R5";
    if (x >= 12'h036 && x <= 12'h037) return "R8";
    if (x >= 12'h030 && x <= 12'h035 && b >= 32) return "R9";
    if (x >= 12'h030 && x <= 12'h033) return "R6";
    if (x >= 12'h034 && x <= 12'h035) return "R7";
    return "R10";
  endfunction

  // Behavioural reference: bit loops and integer arithmetic.
  function automatic logic [31:0] refModel(input logic [11:0] x, input logic [31:0] a,
                                           input logic [31:0] b, output bit ill);
    logic [31:0] r;
    longint      ua, ub;
    int          sa, sb, n;
    bit          left, fillBit;
    ill = 1'b0;
    r   = '0;
    ua  = longint'(a);
    ub  = longint'(b);
    sa  = int'(a);
    sb  = int'(b);
    case (x)
      12'h000, 12'h001: r = 32'(ua + ub);
      12'h002, 12'h003: r = 32'(ua - ub);
      12'h004: r = (sa < sb) ? 32'd1 : (sa == sb) ? 32'd2 : 32'd4;
      12'h005: r = (ua < ub) ? 32'd1 : (ua == ub) ? 32'd2 : 32'd4;
      12'h010: r = (sa > sb) ? a : b;
      12'h011: r = (ua > ub) ? a : b;
      12'h012: r = (sa < sb) ? a : b;
      12'h013: r = (ua < ub) ? a : b;
      12'h020: r = a & b;
      12'h021: r = a | b;
      12'h022: r = a ^ b;
      12'h023: r = ~(a & b);
      12'h024: r = ~(a | b);
      12'h025: r = ~(a ^ b);
      12'h026: r = ~a & b;
      12'h027: r = a & ~b;
      12'h028: r = ~a | b;
      12'h029: r = a | ~b;
      12'h030, 12'h031, 12'h032, 12'h033, 12'h034, 12'h035: begin
        left    = (x == 12'h030 || x == 12'h032 || x == 12'h034);
        fillBit = (x == 12'h034 || x == 12'h035) ? 1'b1 : (x == 12'h031) ? a[31] : 1'b0;
        n       = (ub >= 32) ? 32 : int'(ub);
        for (int i = 0; i < 32; i++) begin
          int src;
          src = left ? i - n : i + n;
          r[i] = (src >= 0 && src < 32) ? a[src] : fillBit;
        end
      end
      12'h036: begin
        n = int'(ub % 32);
        for (int i = 0; i < 32; i++) r[i] = a[(i - n + 32) % 32];
      end
      12'h037: begin
        n = int'(ub % 32);
        for (int i = 0; i < 32; i++) r[i] = a[(i + n) % 32];
      end
      default: begin
        ill = 1'b1;
        r   = '0;
      end
    endcase
    return r;
  endfunction

  task automatic applyCheck(input logic [11:0] x, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    bit          expIll;
    @(posedge clk);
    xop = x;
    opA = a;
    opB = b;
    expR = refModel(x, a, b, expIll);
    @(negedge clk);
    checks++;
    if (result !== expR || illegal !== expIll) begin
      errors++;
      $display("FAIL %s xop=%h a=%h b=%h actual=%h/%b expected=%h/%b",
               reqTag(x, b), x, a, b, result, illegal, expR, expIll);
    end
  endtask

  initial begin
    patA[0]  = 32'h0000_0000; patB[0]  = 32'h0000_0000;
    patA[1]  = 32'h0000_0001; patB[1]  = 32'h0000_0001;
    patA[2]  = 32'hFFFF_FFFF; patB[2]  = 32'h0000_0001;
    patA[3]  = 32'h8000_0000; patB[3]  = 32'h7FFF_FFFF;
    patA[4]  = 32'h7FFF_FFFF; patB[4]  = 32'h8000_0000;
    patA[5]  = 32'h1234_5678; patB[5]  = 32'h0000_001F;
    patA[6]  = 32'h8000_0001; patB[6]  = 32'h0000_0020;
    patA[7]  = 32'hF0F0_A5A5; patB[7]  = 32'h0000_0021;
    patA[8]  = 32'h0F0F_5A5A; patB[8]  = 32'hFFFF_FFE1;
    patA[9]  = 32'hC3C3_C3C3; patB[9]  = 32'h0000_0004;
    patA[10] = 32'h0000_0005; patB[10] = 32'h0000_0005;
    patA[11] = 32'hFFFF_FFFE; patB[11] = 32'hFFFF_FFFF;
    patA[12] = 32'h9E37_79B9; patB[12] = 32'h0000_0010;
    patA[13] = 32'h6B8B_4567; patB[13] = 32'h0000_0000;

    // Initial state: a zero add is legal and returns zero (R1)
    applyCheck(12'h000, 32'h0, 32'h0);

    for (int x = 0; x < 4096; x++) begin
      for (int k = 0; k < NUM_PAT; k++) begin
        applyCheck(12'(x), patA[k], patB[k]);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule